// File: doc/BRIEF.md
# Paired-Page Translation Lookaside Buffer with Fault Classification

This block is the associative translation cache of a memory management unit. Each entry describes two neighbouring virtual pages: an even page and an odd page that share one tag. The page size is chosen per entry, from 4 KB up to 16 MB in steps of four. For every access that the segment checker has found to be mapped, the block takes the virtual address and two flags, one for a write and one for an instruction fetch. It compares the address with all entries at once and picks the even or odd half of the entry that matches. It then checks the valid and dirty bits of that half. The result is either a physical address or a fault code.

On a translation fault the block records what the exception handler needs. It fills the address-tag register (EntryHi) with the failing region, VPN2 and the current ASID. It writes the bad VPN2 into the page-table context registers and captures the failing virtual address. It also states whether a missed lookup should go to the general exception vector, the normal refill vector or the extended refill vector.

Software loads entries through a single-cycle write port. It sets the current ASID by writing the address-tag register.

Top module: `tlb_paired`

## Requirements
- R1: An entry matches when all of the following hold:
  - it has been written since reset;
  - its 2-bit region (address bits 39:38) equals that of the address;
  - its VPN2 equals the address VPN2 (bits 37:13), ignoring the lowest 2*size VPN2 bits;
  - its global bit is set, or its ASID equals the ASID held in the address-tag register.
- R2: The size code is s, from 0 to 6; codes above 6 act as 6. Virtual address bit 12+2*s selects the mapping: 1 selects the odd mapping, 0 the even mapping.
- R3: On a clean hit, the physical address is the PFN with its low 2*s bits cleared, shifted left by 12, ORed with virtual address bits [11+2*s:0].
- R4: If the selected mapping has valid=0, the fault kind is 2 (invalid). The exception code is 3 for a write and 2 otherwise.
- R5: If the mapping is valid, the access is a write and dirty=0, the fault kind is 3 (modified) with exception code 1. A write to a dirty page translates normally.
- R6: If a translated physical address is at or above the MEM_TOP parameter, the fault kind is 4 (bus error).
  - The exception code is 6 for a fetch and 7 otherwise.
  - Only the captured bad address is updated; the address-tag register keeps its value.
- R7: On a fault of kind 1, 2 or 3, the following registers are loaded:
  - the address-tag register gets {region, VPN2, current ASID};
  - context bits [22:4] get VPN2[18:0], and the other context bits keep their value;
  - the extended context gets {region, VPN2, 4'b0};
  - the bad-address register gets the virtual address.
- R8: If no entry matches, the fault kind is 1, with exception code 3 for a write and 2 otherwise. If EXL is set, the vector is 0 (general).
- R9: With EXL clear, a no-match lookup uses vector 2 (extended refill) in three cases: region 0 with UX set, region 3 with KX set, or region 1 with SX set. In all other cases it uses vector 1 (refill).
- R10: If several entries match, the lowest index supplies the translation, and a multi-hit flag is set. The flag stays set until reset.
- R11: A write-port store appears in the entry one clock after it is presented. A lookup in that same cycle still sees the old contents.
- R12: Results appear one clock after the request, with rsp_valid high for exactly that one cycle. A clean hit leaves the fault registers unchanged.
- R13: A software write to the address-tag register sets the current ASID for later lookups. If a fault and a software write occur in the same cycle, the fault's value wins.
- R14: After reset these are all zero: rsp_valid, the multi-hit flag, the fault registers, and every entry's written-since-reset state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Lookup request |
| req_va_i | input | 40 | Virtual address |
| req_write_i | input | 1 | Access is a store |
| req_fetch_i | input | 1 | Access is an instruction fetch |
| st_exl_i | input | 1 | Exception level active |
| st_ux_i | input | 1 | Extended addressing for region 0 |
| st_sx_i | input | 1 | Extended addressing for region 1 |
| st_kx_i | input | 1 | Extended addressing for region 3 |
| ehi_we_i | input | 1 | Software write of the address-tag register |
| ehi_wdata_i | input | 35 | {region, VPN2, ASID} to write |
| tw_en_i | input | 1 | Entry write strobe |
| tw_idx_i | input | 4 | Entry index |
| tw_hi_i | input | 35 | Entry tag {region, VPN2, ASID} |
| tw_lo0_i | input | 26 | Even mapping {PFN[23:0], dirty, valid} |
| tw_lo1_i | input | 26 | Odd mapping {PFN[23:0], dirty, valid} |
| tw_size_i | input | 3 | Page size code s (4 KB * 4^s) |
| tw_global_i | input | 1 | Ignore ASID on match |
| rsp_valid_o | output | 1 | Result valid |
| rsp_pa_o | output | 36 | Physical address (zero on a fault) |
| rsp_fault_o | output | 3 | 0 none, 1 no match, 2 invalid, 3 modified, 4 bus error |
| rsp_exc_o | output | 5 | Exception code |
| rsp_vec_o | output | 2 | 0 general, 1 refill, 2 extended refill |
| entryhi_o | output | 35 | Address-tag register |
| context_o | output | 32 | Page-table context register |
| xcontext_o | output | 31 | Extended context register |
| badvaddr_o | output | 40 | Captured failing virtual address |
| multi_hit_o | output | 1 | Sticky multi-hit flag |

## Verification
Every result is due one clock after the request. This covers the physical address, the fault kind, the exception code and the vector, and also the register updates a fault causes. The bench therefore presents a request on a falling edge, removes it on the next falling edge, and samples all outputs there; the one rising edge in between is the edge that registers the result. Entry writes and address-tag writes take effect after that same single edge. A lookup presented in the same cycle as a write is checked against the old contents, and the next lookup against the new contents.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
    localparam int VA_W      = 40;
    localparam int PA_W      = 36;
    localparam int ASID_W    = 8;
    localparam int REG_W     = 2;
    localparam int OFF_W     = 13;
    localparam int VPN2_W    = VA_W - REG_W - OFF_W;
    localparam int PFN_W     = PA_W - 12;
    localparam int SZ_W      = 3;
    localparam int SZ_MAX    = 6;
    localparam int CTX_W     = 32;
    localparam int CTX_VPN_W = 19;
    localparam int XCTX_W    = REG_W + VPN2_W + 4;
    localparam int EHI_W     = REG_W + VPN2_W + ASID_W;
    localparam int LO_W      = PFN_W + 2;

    typedef struct packed {
        logic [PFN_W-1:0] pfn;
        logic             dirty;
        logic             valid;
    } lo_t;

    typedef struct packed {
        logic [REG_W-1:0]  region;
        logic [VPN2_W-1:0] vpn2;
        logic [ASID_W-1:0] asid;
    } ehi_t;

    typedef struct packed {
        logic            used;
        logic            glob;
        logic [SZ_W-1:0] sz;
        ehi_t            hi;
        lo_t             lo0;
        lo_t             lo1;
    } entry_t;

    typedef enum logic [2:0] {
        FK_NONE     = 3'd0,
        FK_NOMATCH  = 3'd1,
        FK_INVALID  = 3'd2,
        FK_MODIFIED = 3'd3,
        FK_BUSERR   = 3'd4
    } fault_e;

    typedef enum logic [1:0] {
        VEC_GENERAL = 2'd0,
        VEC_REFILL  = 2'd1,
        VEC_XREFILL = 2'd2
    } vec_e;

    localparam logic [4:0] EXC_MOD  = 5'd1;
    localparam logic [4:0] EXC_TLBL = 5'd2;
    localparam logic [4:0] EXC_TLBS = 5'd3;
    localparam logic [4:0] EXC_IBE  = 5'd6;
    localparam logic [4:0] EXC_DBE  = 5'd7;

    function automatic logic [SZ_W-1:0] sz_clamp(input logic [SZ_W-1:0] s);
        return (s > SZ_W'(SZ_MAX)) ? SZ_W'(SZ_MAX) : s;
    endfunction

    // VPN2 bits that take part in the compare for size code s
    function automatic logic [VPN2_W-1:0] vpn_keep(input logic [SZ_W-1:0] s);
        return {VPN2_W{1'b1}} << {s, 1'b0};
    endfunction

    // PFN bits that survive for size code s
    function automatic logic [PFN_W-1:0] pfn_keep(input logic [SZ_W-1:0] s);
        return {PFN_W{1'b1}} << {s, 1'b0};
    endfunction

    // Page offset bits for size code s
    function automatic logic [PA_W-1:0] off_mask(input logic [SZ_W-1:0] s);
        return ~({PA_W{1'b1}} << (6'd12 + {2'b0, s, 1'b0}));
    endfunction
endpackage

// File: rtl/tlb_entry_store.sv
module tlb_entry_store import tlb_pkg::*; #(
    parameter int N_ENT = 16,
    localparam int IDX_W = $clog2(N_ENT)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we_i,
    input  logic [IDX_W-1:0] widx_i,
    input  entry_t           went_i,
    output entry_t           ents_o [N_ENT]
);
    entry_t ents_d [N_ENT];
    entry_t ents_q [N_ENT];

    always_comb begin
        ents_d = ents_q;
        if (we_i) begin
            ents_d[widx_i]      = went_i;
            ents_d[widx_i].used = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ents_q <= '{default: '0};
        else        ents_q <= ents_d;
    end

    assign ents_o = ents_q;

    // R11: a store is visible in the entry after one clock
    p_write_lands_r11: assert property (@(posedge clk) disable iff (!rst_n)
        we_i |=> (ents_q[$past(widx_i)].hi == $past(went_i.hi)) && ents_q[$past(widx_i)].used);
endmodule

// File: rtl/tlb_match_cell.sv
module tlb_match_cell import tlb_pkg::*; (
    input  entry_t             ent_i,
    input  logic [REG_W-1:0]   region_i,
    input  logic [VPN2_W-1:0]  vpn2_i,
    input  logic [ASID_W-1:0]  asid_i,
    output logic               hit_o
);
    logic [VPN2_W-1:0] keep;
    logic              tag_eq;
    logic              asid_ok;

    always_comb begin
        keep    = vpn_keep(sz_clamp(ent_i.sz));
        tag_eq  = (ent_i.hi.region == region_i) && (((ent_i.hi.vpn2 ^ vpn2_i) & keep) == '0);
        asid_ok = ent_i.glob || (ent_i.hi.asid == asid_i);
        hit_o   = ent_i.used && tag_eq && asid_ok;
    end
endmodule

// File: rtl/tlb_prio_pick.sv
module tlb_prio_pick #(
    parameter int N_ENT = 16,
    localparam int IDX_W = $clog2(N_ENT)
) (
    input  logic [N_ENT-1:0] hits_i,
    output logic [IDX_W-1:0] idx_o,
    output logic             any_o,
    output logic             multi_o
);
    always_comb begin
        idx_o = '0;
        for (int i = N_ENT - 1; i >= 0; i--) begin
            if (hits_i[i]) idx_o = IDX_W'(i);
        end
        any_o   = |hits_i;
        multi_o = (hits_i & (hits_i - 1'b1)) != '0;
    end
endmodule

// File: rtl/tlb_paired.sv
module tlb_paired import tlb_pkg::*; #(
    parameter int N_ENT = 16,
    parameter logic [PA_W-1:0] MEM_TOP = 36'h0_8000_0000,
    localparam int IDX_W = $clog2(N_ENT)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid_i,
    input  logic [VA_W-1:0]   req_va_i,
    input  logic              req_write_i,
    input  logic              req_fetch_i,
    input  logic              st_exl_i,
    input  logic              st_ux_i,
    input  logic              st_sx_i,
    input  logic              st_kx_i,
    input  logic              ehi_we_i,
    input  logic [EHI_W-1:0]  ehi_wdata_i,
    input  logic              tw_en_i,
    input  logic [IDX_W-1:0]  tw_idx_i,
    input  logic [EHI_W-1:0]  tw_hi_i,
    input  logic [LO_W-1:0]   tw_lo0_i,
    input  logic [LO_W-1:0]   tw_lo1_i,
    input  logic [SZ_W-1:0]   tw_size_i,
    input  logic              tw_global_i,
    output logic              rsp_valid_o,
    output logic [PA_W-1:0]   rsp_pa_o,
    output logic [2:0]        rsp_fault_o,
    output logic [4:0]        rsp_exc_o,
    output logic [1:0]        rsp_vec_o,
    output logic [EHI_W-1:0]  entryhi_o,
    output logic [CTX_W-1:0]  context_o,
    output logic [XCTX_W-1:0] xcontext_o,
    output logic [VA_W-1:0]   badvaddr_o,
    output logic              multi_hit_o
);
    typedef struct packed {
        logic              rsp_valid;
        logic [PA_W-1:0]   pa;
        fault_e            fault;
        logic [4:0]        exc;
        vec_e              vec;
        ehi_t              ehi;
        logic [CTX_W-1:0]  ctx;
        logic [XCTX_W-1:0] xctx;
        logic [VA_W-1:0]   badv;
        logic              multi;
    } st_t;

    st_t d, q;

    // Entry storage and write port
    entry_t went;
    entry_t ents [N_ENT];

    always_comb begin
        went.used = 1'b1;
        went.glob = tw_global_i;
        went.sz   = tw_size_i;
        went.hi   = ehi_t'(tw_hi_i);
        went.lo0  = lo_t'(tw_lo0_i);
        went.lo1  = lo_t'(tw_lo1_i);
    end

    tlb_entry_store #(.N_ENT(N_ENT)) u_store (
        .clk    (clk),
        .rst_n  (rst_n),
        .we_i   (tw_en_i),
        .widx_i (tw_idx_i),
        .went_i (went),
        .ents_o (ents)
    );

    // Address fields
    logic [REG_W-1:0]  va_region;
    logic [VPN2_W-1:0] va_vpn2;
    assign va_region = req_va_i[VA_W-1 -: REG_W];
    assign va_vpn2   = req_va_i[VA_W-REG_W-1 : OFF_W];

    // Parallel compare
    logic [N_ENT-1:0] hits;
    for (genvar g = 0; g < N_ENT; g++) begin : g_cmp
        tlb_match_cell u_cell (
            .ent_i    (ents[g]),
            .region_i (va_region),
            .vpn2_i   (va_vpn2),
            .asid_i   (q.ehi.asid),
            .hit_o    (hits[g])
        );
    end

    logic [IDX_W-1:0] hit_idx;
    logic             hit_any;
    logic             hit_multi;

    tlb_prio_pick #(.N_ENT(N_ENT)) u_pick (
        .hits_i  (hits),
        .idx_o   (hit_idx),
        .any_o   (hit_any),
        .multi_o (hit_multi)
    );

    // Half select and address formation
    logic [SZ_W-1:0] szc;
    logic [5:0]      sel_bit;
    lo_t             lo_sel;
    logic [PA_W-1:0] pa_calc;
    logic            ext_refill;
    logic            tlb_fault;

    always_comb begin
        szc     = sz_clamp(ents[hit_idx].sz);
        sel_bit = 6'd12 + {2'b0, szc, 1'b0};
        lo_sel  = req_va_i[sel_bit] ? ents[hit_idx].lo1 : ents[hit_idx].lo0;
        pa_calc = {lo_sel.pfn & pfn_keep(szc), 12'b0} | (req_va_i[PA_W-1:0] & off_mask(szc));
        ext_refill = ((va_region == 2'd0) && st_ux_i) ||
                     ((va_region == 2'd3) && st_kx_i) ||
                     ((va_region == 2'd1) && st_sx_i);
    end

    // Next state
    always_comb begin
        d           = q;
        tlb_fault   = 1'b0;
        d.rsp_valid = req_valid_i;
        if (ehi_we_i) d.ehi = ehi_t'(ehi_wdata_i);
        if (req_valid_i) begin
            d.multi = q.multi | hit_multi;
            d.pa    = '0;
            d.fault = FK_NONE;
            d.exc   = '0;
            d.vec   = VEC_GENERAL;
            if (!hit_any) begin
                tlb_fault = 1'b1;
                d.fault   = FK_NOMATCH;
                d.exc     = req_write_i ? EXC_TLBS : EXC_TLBL;
                if (!st_exl_i) d.vec = ext_refill ? VEC_XREFILL : VEC_REFILL;
            end else if (!lo_sel.valid) begin
                tlb_fault = 1'b1;
                d.fault   = FK_INVALID;
                d.exc     = req_write_i ? EXC_TLBS : EXC_TLBL;
            end else if (req_write_i && !lo_sel.dirty) begin
                tlb_fault = 1'b1;
                d.fault   = FK_MODIFIED;
                d.exc     = EXC_MOD;
            end else if (pa_calc >= MEM_TOP) begin
                d.fault = FK_BUSERR;
                d.exc   = req_fetch_i ? EXC_IBE : EXC_DBE;
                d.badv  = req_va_i;
            end else begin
                d.pa = pa_calc;
            end
            if (tlb_fault) begin
                d.ehi.region = va_region;
                d.ehi.vpn2   = va_vpn2;
                d.ehi.asid   = q.ehi.asid;
                d.ctx[CTX_VPN_W+3:4] = va_vpn2[CTX_VPN_W-1:0];
                d.xctx = {va_region, va_vpn2, 4'b0};
                d.badv = req_va_i;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign rsp_valid_o = q.rsp_valid;
    assign rsp_pa_o    = q.pa;
    assign rsp_fault_o = q.fault;
    assign rsp_exc_o   = q.exc;
    assign rsp_vec_o   = q.vec;
    assign entryhi_o   = q.ehi;
    assign context_o   = q.ctx;
    assign xcontext_o  = q.xctx;
    assign badvaddr_o  = q.badv;
    assign multi_hit_o = q.multi;

    // R7: a translation fault captures the requesting address
    p_fault_badv_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (q.rsp_valid && (q.fault inside {FK_NOMATCH, FK_INVALID, FK_MODIFIED}))
        |-> (q.badv == $past(req_va_i)) && (q.ehi.vpn2 == $past(req_va_i[VA_W-REG_W-1:OFF_W])));

    // R5: modified faults only come from stores
    p_mod_on_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (q.rsp_valid && q.fault == FK_MODIFIED) |-> $past(req_write_i));

    // R8: a miss under EXL goes to the general vector
    p_exl_general_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (q.rsp_valid && q.fault == FK_NOMATCH && $past(st_exl_i)) |-> (q.vec == VEC_GENERAL));

    // R10: multi-hit flag is sticky
    p_multi_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        q.multi |=> q.multi);

    // R6: bus error leaves the address-tag register alone
    p_buserr_keeps_ehi_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (q.rsp_valid && q.fault == FK_BUSERR && !$past(ehi_we_i)) |-> $stable(q.ehi));

    // R12: a clean hit does not disturb the bad-address register
    p_hit_keeps_badv_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (q.rsp_valid && q.fault == FK_NONE) |-> $stable(q.badv));
endmodule

// File: tb/tlb_paired_test.sv
`timescale 1ns/1ps
module tlb_paired_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 0, req_write = 0, req_fetch = 0;
    logic [39:0] req_va = '0;
    logic        exl = 0, ux = 0, sx = 0, kx = 0;
    logic        ehi_we = 0;
    logic [34:0] ehi_wdata = '0;
    logic        tw_en = 0;
    logic [3:0]  tw_idx = '0;
    logic [34:0] tw_hi = '0;
    logic [25:0] tw_lo0 = '0, tw_lo1 = '0;
    logic [2:0]  tw_size = '0;
    logic        tw_global = 0;
    logic        rsp_valid;
    logic [35:0] rsp_pa;
    logic [2:0]  rsp_fault;
    logic [4:0]  rsp_exc;
    logic [1:0]  rsp_vec;
    logic [34:0] entryhi;
    logic [31:0] context_r;
    logic [30:0] xcontext_r;
    logic [39:0] badvaddr;
    logic        multi_hit;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #2.5 clk = ~clk;

    tlb_paired uut (
        .clk(clk), .rst_n(rst_n),
        .req_valid_i(req_valid), .req_va_i(req_va), .req_write_i(req_write), .req_fetch_i(req_fetch),
        .st_exl_i(exl), .st_ux_i(ux), .st_sx_i(sx), .st_kx_i(kx),
        .ehi_we_i(ehi_we), .ehi_wdata_i(ehi_wdata),
        .tw_en_i(tw_en), .tw_idx_i(tw_idx), .tw_hi_i(tw_hi), .tw_lo0_i(tw_lo0), .tw_lo1_i(tw_lo1),
        .tw_size_i(tw_size), .tw_global_i(tw_global),
        .rsp_valid_o(rsp_valid), .rsp_pa_o(rsp_pa), .rsp_fault_o(rsp_fault), .rsp_exc_o(rsp_exc),
        .rsp_vec_o(rsp_vec), .entryhi_o(entryhi), .context_o(context_r), .xcontext_o(xcontext_r),
        .badvaddr_o(badvaddr), .multi_hit_o(multi_hit)
    );

    function automatic logic [39:0] mkva(input logic [1:0] r, input logic [24:0] v, input logic [12:0] o);
        return {r, v, o};
    endfunction

    typedef struct packed {
        logic [39:0] va;
        logic        wr, fe, xl, u, k, s;
        logic [2:0]  fk;
        logic [4:0]  exc;
        logic [1:0]  vec;
        logic [35:0] pa;
        logic [7:0]  rq;
    } vec_t;

    localparam int NV = 20;
    localparam vec_t TV [NV] = '{
        '{mkva(2'd0, 25'h10, 13'h0ABC), 0,0,0,0,0,0, 3'd0, 5'd0, 2'd0, 36'h100ABC,  8'd3},  // R3 even half
        '{mkva(2'd0, 25'h10, 13'h1123), 0,0,0,0,0,0, 3'd0, 5'd0, 2'd0, 36'h200123,  8'd2},  // R2 odd half
        '{mkva(2'd0, 25'h10, 13'h1123), 1,0,0,0,0,0, 3'd3, 5'd1, 2'd0, 36'h0,       8'd5},  // R5 clean page write
        '{mkva(2'd0, 25'h10, 13'h0004), 1,0,0,0,0,0, 3'd0, 5'd0, 2'd0, 36'h100004,  8'd5},  // R5 dirty page write
        '{mkva(2'd0, 25'h20, 13'h0010), 0,0,0,0,0,0, 3'd0, 5'd0, 2'd0, 36'h300010,  8'd1},  // R1 global entry
        '{mkva(2'd0, 25'h20, 13'h1000), 0,0,0,0,0,0, 3'd2, 5'd2, 2'd0, 36'h0,       8'd4},  // R4 invalid load
        '{mkva(2'd0, 25'h20, 13'h1000), 1,0,0,0,0,0, 3'd2, 5'd3, 2'd0, 36'h0,       8'd4},  // R4 invalid store
        '{mkva(2'd0, 25'h20, 13'h1000), 0,1,0,0,0,0, 3'd2, 5'd2, 2'd0, 36'h0,       8'd4},  // R4 invalid fetch
        '{mkva(2'd3, 25'h45, 13'h0100), 0,0,0,0,0,0, 3'd0, 5'd0, 2'd0, 36'h123A100, 8'd2},  // R2 64K even
        '{mkva(2'd3, 25'h4D, 13'h0007), 0,0,0,0,0,0, 3'd0, 5'd0, 2'd0, 36'h567A007, 8'd3},  // R3 64K odd
        '{mkva(2'd3, 25'h50, 13'h0000), 0,0,0,0,1,0, 3'd1, 5'd2, 2'd2, 36'h0,       8'd9},  // R9 region 3 KX
        '{mkva(2'd3, 25'h50, 13'h0000), 0,0,0,1,0,1, 3'd1, 5'd2, 2'd1, 36'h0,       8'd9},  // R9 region 3 no KX
        '{mkva(2'd3, 25'h50, 13'h0000), 1,0,1,0,1,0, 3'd1, 5'd3, 2'd0, 36'h0,       8'd8},  // R8 EXL set
        '{mkva(2'd0, 25'h30, 13'h0000), 0,0,0,1,0,0, 3'd1, 5'd2, 2'd2, 36'h0,       8'd1},  // R1 ASID mismatch
        '{mkva(2'd0, 25'h31, 13'h0000), 0,0,0,0,1,1, 3'd1, 5'd2, 2'd1, 36'h0,       8'd9},  // R9 region 0 no UX
        '{mkva(2'd1, 25'h61, 13'h0000), 0,0,0,0,0,1, 3'd1, 5'd2, 2'd2, 36'h0,       8'd9},  // R9 region 1 SX
        '{mkva(2'd2, 25'h10, 13'h0000), 0,0,0,1,1,1, 3'd1, 5'd2, 2'd1, 36'h0,       8'd9},  // R9 region 2
        '{mkva(2'd0, 25'h50, 13'h0000), 0,0,0,0,0,0, 3'd4, 5'd7, 2'd0, 36'h0,       8'd6},  // R6 data bus error
        '{mkva(2'd0, 25'h50, 13'h0000), 0,1,0,0,0,0, 3'd4, 5'd6, 2'd0, 36'h0,       8'd6},  // R6 fetch bus error
        '{mkva(2'd1, 25'h60, 13'h0FF0), 0,0,0,0,0,0, 3'd0, 5'd0, 2'd0, 36'h700FF0,  8'd10}  // R10 lowest index
    };

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr_entry(input int idx, input logic [1:0] r, input logic [24:0] v, input logic [7:0] a,
                            input logic g, input logic [2:0] sz,
                            input logic [23:0] p0, input logic d0, input logic v0,
                            input logic [23:0] p1, input logic d1, input logic v1);
        @(negedge clk);
        tw_en = 1; tw_idx = 4'(idx); tw_hi = {r, v, a}; tw_global = g; tw_size = sz;
        tw_lo0 = {p0, d0, v0}; tw_lo1 = {p1, d1, v1};
        @(negedge clk);
        tw_en = 0;
    endtask

    task automatic set_asid(input logic [7:0] a);
        @(negedge clk);
        ehi_we = 1; ehi_wdata = {2'd0, 25'd0, a};
        @(negedge clk);
        ehi_we = 0;
    endtask

    task automatic look(input logic [39:0] va, input logic w, f, x, u, k, s);
        @(negedge clk);
        req_valid = 1; req_va = va; req_write = w; req_fetch = f;
        exl = x; ux = u; kx = k; sx = s;
        @(negedge clk);
        req_valid = 0; req_write = 0; req_fetch = 0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: run did not finish");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        logic [39:0] va_a, va_b;
        repeat (3) @(negedge clk);
        // R14 reset state
        chk("R14 rsp_valid", rsp_valid, 0);
        chk("R14 entryhi", entryhi, 0);
        chk("R14 badvaddr", badvaddr, 0);
        chk("R14 multi_hit", multi_hit, 0);
        rst_n = 1;
        // R14 no entry matches straight after reset
        look(mkva(2'd0, 25'h0, 13'h0), 0,0,0,0,0,0);
        chk("R14 empty after reset", rsp_fault, 1);

        set_asid(8'h05);
        wr_entry(0, 2'd0, 25'h10, 8'h05, 0, 3'd0, 24'h100, 1, 1, 24'h200, 0, 1);
        wr_entry(1, 2'd0, 25'h20, 8'h07, 1, 3'd0, 24'h300, 1, 1, 24'h0,   0, 0);
        wr_entry(2, 2'd3, 25'h40, 8'h05, 0, 3'd2, 24'h01234, 1, 1, 24'h05670, 1, 1);
        wr_entry(3, 2'd0, 25'h30, 8'h09, 0, 3'd0, 24'h400, 1, 1, 24'h400, 1, 1);
        wr_entry(4, 2'd0, 25'h50, 8'h05, 0, 3'd0, 24'hF00000, 1, 1, 24'h0, 0, 0);
        wr_entry(5, 2'd1, 25'h60, 8'h05, 0, 3'd0, 24'h700, 1, 1, 24'h0, 0, 0);
        wr_entry(6, 2'd1, 25'h60, 8'h05, 0, 3'd0, 24'h800, 1, 1, 24'h0, 0, 0);
        chk("R10 multi_hit clear before overlap", multi_hit, 0);

        for (int i = 0; i < NV; i++) begin
            look(TV[i].va, TV[i].wr, TV[i].fe, TV[i].xl, TV[i].u, TV[i].k, TV[i].s);
            chk($sformatf("R%0d vec%0d valid", TV[i].rq, i), rsp_valid, 1);
            chk($sformatf("R%0d vec%0d fault", TV[i].rq, i), rsp_fault, TV[i].fk);
            chk($sformatf("R%0d vec%0d exc", TV[i].rq, i), rsp_exc, TV[i].exc);
            chk($sformatf("R%0d vec%0d vector", TV[i].rq, i), rsp_vec, TV[i].vec);
            chk($sformatf("R%0d vec%0d pa", TV[i].rq, i), rsp_pa, TV[i].pa);
        end
        chk("R10 multi_hit set", multi_hit, 1);

        // R7 fault register contents
        va_a = mkva(2'd3, 25'h50, 13'h0123);
        look(va_a, 0,0,0,0,1,0);
        chk("R7 entryhi", entryhi, {2'd3, 25'h50, 8'h05});
        chk("R7 context", context_r, {9'd0, 19'h50, 4'd0});
        chk("R7 xcontext", xcontext_r, {2'd3, 25'h50, 4'd0});
        chk("R7 badvaddr", badvaddr, va_a);

        // R6 bus error updates only the bad address
        va_b = mkva(2'd0, 25'h50, 13'h0040);
        look(va_b, 0,0,0,0,0,0);
        chk("R6 entryhi kept", entryhi, {2'd3, 25'h50, 8'h05});
        chk("R6 badvaddr", badvaddr, va_b);

        // R12 hit keeps fault registers, one-cycle valid pulse
        look(mkva(2'd0, 25'h10, 13'h0ABC), 0,0,0,0,0,0);
        chk("R12 hit valid", rsp_valid, 1);
        chk("R12 badvaddr kept", badvaddr, va_b);
        chk("R12 context kept", context_r, {9'd0, 19'h50, 4'd0});
        @(negedge clk);
        chk("R12 valid drops", rsp_valid, 0);

        // R13 ASID change
        set_asid(8'h06);
        look(mkva(2'd0, 25'h10, 13'h0ABC), 0,0,0,0,0,0);
        chk("R13 old ASID misses", rsp_fault, 1);
        look(mkva(2'd0, 25'h20, 13'h0010), 0,0,0,0,0,0);
        chk("R13 global still hits", rsp_pa, 36'h300010);
        // R13 fault beats same-cycle software write
        @(negedge clk);
        ehi_we = 1; ehi_wdata = {2'd0, 25'd0, 8'h09};
        req_valid = 1; req_va = mkva(2'd0, 25'h33, 13'h0); req_write = 0; req_fetch = 0;
        exl = 0; ux = 0; kx = 0; sx = 0;
        @(negedge clk);
        ehi_we = 0; req_valid = 0;
        chk("R13 fault wins entryhi", entryhi, {2'd0, 25'h33, 8'h06});

        // R11 write and lookup in the same cycle
        @(negedge clk);
        tw_en = 1; tw_idx = 4'd7; tw_hi = {2'd0, 25'h70, 8'h06}; tw_global = 0; tw_size = 3'd0;
        tw_lo0 = {24'h777, 1'b1, 1'b1}; tw_lo1 = '0;
        req_valid = 1; req_va = mkva(2'd0, 25'h70, 13'h0010);
        @(negedge clk);
        tw_en = 0; req_valid = 0;
        chk("R11 same-cycle lookup sees old", rsp_fault, 1);
        look(mkva(2'd0, 25'h70, 13'h0010), 0,0,0,0,0,0);
        chk("R11 new entry hits", rsp_pa, 36'h777010);

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule